// File: doc/BRIEF.md
# Chainable Synchronous Up-Counter with Preset

This block is a binary up-counter built from identical narrow slices that share one rising clock edge. Every slice has a synchronous active-low clear and a synchronous active-low preset. The preset copies a parallel value into the counter. There are two active-high enables. The broadcast enable goes to every slice in common. The carry enable is the global enable of the lowest slice and reaches the terminal flag combinationally. Above the lowest slice, each slice takes its carry enable from the terminal flag of the slice below it. The slices therefore behave as one counter of the full width with no ripple between clock edges.

Clear and preset are synchronous. A counter of modulus N can be made by driving clear low while the count equals N-1, so the count returns to zero on the next edge. After power-up the counter holds an unknown value until the first clear or preset edge.

Top module: `ctr_chain`

## Requirements
- R1: When `clr_n` is 0 at a rising edge of `clk`, `count` becomes all zeros on that edge. This holds for any level of `ld_n`, `en_bcast`, `en_carry` and `load_val`.
- R2: When `clr_n` is 1 and `ld_n` is 0 at a rising edge, `count` takes the value of `load_val` on that edge, for any level of either enable.
- R3: When `clr_n`, `ld_n`, `en_bcast` and `en_carry` are all 1 at a rising edge, `count` increases by exactly one modulo 2^(STAGE_W*STAGES). The largest value (all ones) wraps to zero.
- R4: When `clr_n` and `ld_n` are both 1 and at least one of `en_bcast` or `en_carry` is 0 at a rising edge, `count` keeps its value.
- R5: `carry_out` is 1 exactly when `en_carry` is 1 and every bit of `count` is 1. It follows a change of `en_carry` within the same clock cycle, with no clock edge between.
- R6: The slices are STAGE_W bits wide and are ordered least significant first. A slice other than the lowest advances only on a counting edge at which all lower bits of `count` are ones. With the default 4-bit slices, counting from 0x0F gives 0x10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every slice updates on its rising edge |
| clr_n | input | 1 | Synchronous clear, active low, highest priority |
| ld_n | input | 1 | Synchronous preset from `load_val`, active low |
| en_bcast | input | 1 | Count enable shared by all slices |
| en_carry | input | 1 | Carry enable of the lowest slice; also gates `carry_out` |
| load_val | input | STAGE_W*STAGES | Value taken on a preset edge |
| count | output | STAGE_W*STAGES | Current counter value |
| carry_out | output | 1 | Terminal flag of the top slice, used to chain a further counter |

## Verification
The clocked properties assume that every control input is at a known 0 or 1 level at each rising edge, and that the inputs change only away from that edge. They also take the counter value as meaningful only once a clear or a preset has happened. Each property stays disabled until that first clear or preset edge. The bench changes all inputs on falling edges and opens every run with a clear. It changes `en_carry` in the middle of a cycle only while the counter is held, so that it can observe the combinational path to `carry_out`.

// File: rtl/ctr_pkg.sv
package ctr_pkg;

   // Operating mode of one counter slice, in falling priority order
   typedef enum logic [1:0] {
      MODE_CLEAR = 2'd3,
      MODE_LOAD  = 2'd2,
      MODE_COUNT = 2'd1,
      MODE_HOLD  = 2'd0
   } ctr_mode_e;

   // Priority resolution of the four control levels
   function automatic ctr_mode_e pick_mode(input logic clr_n,
                                           input logic ld_n,
                                           input logic en_bcast,
                                           input logic en_carry);
      ctr_mode_e m;
      if (!clr_n)                    m = MODE_CLEAR;
      else if (!ld_n)                m = MODE_LOAD;
      else if (en_bcast && en_carry) m = MODE_COUNT;
      else                           m = MODE_HOLD;
      return m;
   endfunction

endpackage

// File: rtl/ctr_mode_dec.sv
module ctr_mode_dec
   import ctr_pkg::*;
(
   input  logic      clr_n,
   input  logic      ld_n,
   input  logic      en_bcast,
   input  logic      en_carry,
   output ctr_mode_e mode
);

   always_comb begin
      mode = pick_mode(clr_n, ld_n, en_bcast, en_carry);
   end

endmodule

// File: rtl/ctr_stage.sv
module ctr_stage
   import ctr_pkg::*;
#(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         clr_n,
   input  logic         ld_n,
   input  logic         en_bcast,
   input  logic         en_carry,
   input  logic [W-1:0] load_val,
   output logic [W-1:0] value,
   output logic         term
);

   localparam logic [W-1:0] ONE  = W'(1);
   localparam logic [W-1:0] ZERO = '0;

   if (W < 1) begin : g_bad_width
      $error("ctr_stage: W must be at least 1");
   end

   ctr_mode_e    mode;
   logic [W-1:0] value_nx;
   logic         all_ones;

   ctr_mode_dec u_dec (
      .clr_n    (clr_n),
      .ld_n     (ld_n),
      .en_bcast (en_bcast),
      .en_carry (en_carry),
      .mode     (mode)
   );

   always_comb begin
      unique case (mode)
         MODE_CLEAR: value_nx = ZERO;
         MODE_LOAD:  value_nx = load_val;
         MODE_COUNT: value_nx = value + ONE;
         default:    value_nx = value;
      endcase
   end

   always_ff @(posedge clk) begin
      value <= value_nx;
   end

   assign all_ones = &value;
   assign term     = en_carry & all_ones;

   // Assertion support: value is meaningful after the first clear or preset
   logic primed = 1'b0;
   always_ff @(posedge clk) begin
      if (!clr_n || !ld_n) primed <= 1'b1;
   end

   // R1: clear wins over all other controls
   a_r1_clear_wins: assert property (@(posedge clk)
      (!clr_n) |=> (value == ZERO));

   // R2: preset copies the data regardless of enables
   a_r2_preset_copies: assert property (@(posedge clk)
      (clr_n && !ld_n) |=> (value == $past(load_val)));

   // R3: one step per counting edge, wrapping at the top
   a_r3_single_step: assert property (@(posedge clk) disable iff (!primed)
      (clr_n && ld_n && en_bcast && en_carry) |=> (value == $past(value) + ONE));

   // R4: a missing enable freezes the slice
   a_r4_hold_freezes: assert property (@(posedge clk) disable iff (!primed)
      (clr_n && ld_n && !(en_bcast && en_carry)) |=> $stable(value));

endmodule

// File: rtl/ctr_carry_link.sv
module ctr_carry_link #(
   parameter int STAGES = 2
) (
   input  logic              en_carry,
   input  logic [STAGES-1:0] stage_term,
   output logic [STAGES-1:0] stage_cin
);

   if (STAGES < 1) begin : g_bad_stages
      $error("ctr_carry_link: STAGES must be at least 1");
   end

   // Lowest slice sees the global carry enable; each higher slice the
   // terminal flag of its neighbour below.
   assign stage_cin[0] = en_carry;

   if (STAGES > 1) begin : g_link
      for (genvar k = 1; k < STAGES; k++) begin : g_hop
         assign stage_cin[k] = stage_term[k-1];
      end
   end

endmodule

// File: rtl/ctr_chain.sv
module ctr_chain #(
   parameter int STAGE_W = 4,
   parameter int STAGES  = 2
) (
   input  logic                       clk,
   input  logic                       clr_n,
   input  logic                       ld_n,
   input  logic                       en_bcast,
   input  logic                       en_carry,
   input  logic [STAGE_W*STAGES-1:0]  load_val,
   output logic [STAGE_W*STAGES-1:0]  count,
   output logic                       carry_out
);

   localparam int TOTAL_W = STAGE_W * STAGES;

   if (STAGE_W < 1) begin : g_bad_w
      $error("ctr_chain: STAGE_W must be at least 1");
   end
   if (STAGES < 1) begin : g_bad_n
      $error("ctr_chain: STAGES must be at least 1");
   end

   logic [STAGES-1:0] stage_term;
   logic [STAGES-1:0] stage_cin;

   ctr_carry_link #(.STAGES(STAGES)) u_link (
      .en_carry   (en_carry),
      .stage_term (stage_term),
      .stage_cin  (stage_cin)
   );

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      ctr_stage #(.W(STAGE_W)) u_stage (
         .clk      (clk),
         .clr_n    (clr_n),
         .ld_n     (ld_n),
         .en_bcast (en_bcast),
         .en_carry (stage_cin[s]),
         .load_val (load_val[s*STAGE_W +: STAGE_W]),
         .value    (count[s*STAGE_W +: STAGE_W]),
         .term     (stage_term[s])
      );
   end

   assign carry_out = stage_term[STAGES-1];

   // Assertion support
   logic primed = 1'b0;
   always_ff @(posedge clk) begin
      if (!clr_n || !ld_n) primed <= 1'b1;
   end

   // R5: terminal flag tied to carry enable and full count
   a_r5_terminal_flag: assert property (@(posedge clk) disable iff (!primed)
      carry_out == (en_carry && (&count)));

   // R3: whole-width wrap from all ones to zero
   a_r3_full_wrap: assert property (@(posedge clk) disable iff (!primed)
      (clr_n && ld_n && en_bcast && en_carry && (&count)) |=> (count == '0));

   // R6: an upper slice only advances when all lower bits are ones
   if (STAGES > 1) begin : g_upper_chk
      for (genvar s = 1; s < STAGES; s++) begin : g_u
         a_r6_upper_waits: assert property (@(posedge clk) disable iff (!primed)
            (clr_n && ld_n && !(&count[s*STAGE_W-1:0]))
               |=> $stable(count[s*STAGE_W +: STAGE_W]));
      end
   end

   // Width sanity for the flattened vectors
   initial begin
      a_width_total: assert ($bits(count) == TOTAL_W);
   end

endmodule

// File: tb/test_ctr_chain.sv
module test_ctr_chain;

   localparam int W = 8;
   localparam int NVEC = 16;
   localparam int WATCHDOG_CYC = 200000;

   logic         clk = 1'b0;
   logic         clr_n = 1'b1;
   logic         ld_n = 1'b1;
   logic         en_bcast = 1'b0;
   logic         en_carry = 1'b0;
   logic [W-1:0] load_val = '0;
   logic [W-1:0] count;
   logic         carry_out;

   int checks = 0;
   int failures = 0;

   always #4 clk = ~clk;

   ctr_chain #(.STAGE_W(4), .STAGES(2)) i_ctr_chain (
      .clk       (clk),
      .clr_n     (clr_n),
      .ld_n      (ld_n),
      .en_bcast  (en_bcast),
      .en_carry  (en_carry),
      .load_val  (load_val),
      .count     (count),
      .carry_out (carry_out)
   );

   // Vector: {req, clr_n, ld_n, en_bcast, en_carry, load_val, exp_count, exp_carry}
   localparam logic [23:0] VEC [NVEC] = '{
      {3'd1, 1'b0, 1'b0, 1'b1, 1'b1, 8'hAA, 8'h00, 1'b0}, // R1 clear beats preset
      {3'd2, 1'b1, 1'b0, 1'b0, 1'b0, 8'hFC, 8'hFC, 1'b0}, // R2 preset, enables low
      {3'd3, 1'b1, 1'b1, 1'b1, 1'b1, 8'h00, 8'hFD, 1'b0}, // R3 step
      {3'd3, 1'b1, 1'b1, 1'b1, 1'b1, 8'h00, 8'hFE, 1'b0}, // R3 step
      {3'd5, 1'b1, 1'b1, 1'b1, 1'b1, 8'h00, 8'hFF, 1'b1}, // R5 flag at all ones
      {3'd3, 1'b1, 1'b1, 1'b1, 1'b1, 8'h00, 8'h00, 1'b0}, // R3 wrap
      {3'd4, 1'b1, 1'b1, 1'b0, 1'b1, 8'h55, 8'h00, 1'b0}, // R4 broadcast low
      {3'd4, 1'b1, 1'b1, 1'b1, 1'b0, 8'h55, 8'h00, 1'b0}, // R4 carry low
      {3'd2, 1'b1, 1'b0, 1'b0, 1'b1, 8'h0E, 8'h0E, 1'b0}, // R2 preset
      {3'd6, 1'b1, 1'b1, 1'b1, 1'b1, 8'h00, 8'h0F, 1'b0}, // R6 lower full, no flag
      {3'd6, 1'b1, 1'b1, 1'b1, 1'b1, 8'h00, 8'h10, 1'b0}, // R6 carry into upper slice
      {3'd2, 1'b1, 1'b0, 1'b1, 1'b1, 8'hFF, 8'hFF, 1'b1}, // R2 preset ignores enables
      {3'd5, 1'b1, 1'b1, 1'b0, 1'b1, 8'h00, 8'hFF, 1'b1}, // R5 held full, flag on
      {3'd5, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 8'hFF, 1'b0}, // R5 carry low, flag off
      {3'd1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h77, 8'h00, 1'b0}, // R1 clear, enables low
      {3'd2, 1'b1, 1'b0, 1'b0, 1'b0, 8'h3C, 8'h3C, 1'b0}  // R2 preset
   };

   task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   initial begin : watchdog
      repeat (WATCHDOG_CYC) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin : main
      logic [W-1:0] exp_v;
      @(negedge clk);

      // Table walk: drive on a falling edge, check at the next one
      for (int i = 0; i < NVEC; i++) begin
         {clr_n, ld_n, en_bcast, en_carry, load_val} = VEC[i][20:9];
         @(negedge clk);
         check($sformatf("R%0d vec%0d count", VEC[i][23:21], i), count, VEC[i][8:1]);
         check($sformatf("R%0d vec%0d carry", VEC[i][23:21], i), W'(carry_out), W'(VEC[i][0]));
      end

      // R5: combinational path from carry enable, no edge in between
      clr_n = 1'b1; ld_n = 1'b0; load_val = 8'hFF; en_bcast = 1'b0; en_carry = 1'b1;
      @(negedge clk);
      ld_n = 1'b1;
      @(posedge clk);
      #2 en_carry = 1'b0;
      #1 check("R5 flag drops with carry enable", W'(carry_out), 8'h00);
      en_carry = 1'b1;
      #1 check("R5 flag rises with carry enable", W'(carry_out), 8'h01);
      check("R4 held value during flag test", count, 8'hFF);

      // R3 / R6: free run over more than the full range
      @(negedge clk);
      clr_n = 1'b0;
      @(negedge clk);
      check("R1 clear before free run", count, 8'h00);
      clr_n = 1'b1; en_bcast = 1'b1; en_carry = 1'b1;
      exp_v = 8'h00;
      for (int c = 0; c < 300; c++) begin
         @(negedge clk);
         exp_v = exp_v + 8'h01;
         check("R3 free-run count", count, exp_v);
         check("R5 free-run flag", W'(carry_out), W'(exp_v == 8'hFF));
      end

      // R4: alternating enable drops freeze the count
      for (int c = 0; c < 8; c++) begin
         en_bcast = c[0];
         en_carry = ~c[0];
         @(negedge clk);
         check("R4 hold with one enable low", count, exp_v);
      end

      // R1: modulus ten by clearing at nine
      clr_n = 1'b0; en_bcast = 1'b1; en_carry = 1'b1;
      @(negedge clk);
      exp_v = 8'h00;
      for (int c = 0; c < 25; c++) begin
         clr_n = (count != 8'd9);
         @(negedge clk);
         exp_v = (exp_v == 8'd9) ? 8'd0 : exp_v + 8'd1;
         check("R1 modulus-ten sequence", count, exp_v);
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule